// File: doc/BRIEF.md
# Conversion Sequence Controller

This block schedules conversion sequences for an eight-input converter. A configuration write starts a sequence, either at once or when an external trigger fires. For each conversion the block chooses an input channel, issues a one-cycle start pulse to the converter core, and waits for the core's done pulse. It then stores the returned sample in one of eight result slots and sets that slot's complete flag.

A sequence holds between one and eight conversions. Every conversion can sample the start channel, or the channel can step upward and wrap past the last input. Results go either to the slot that matches the conversion's position in the sequence, or to a running ring pointer. Sequences run once or repeat without a break. Sticky status bits report a completed sequence, a result that was overwritten before it was read, and a trigger that arrived while the block was busy. An interrupt line follows the sequence-complete bit when enabled. Software reads results through a slot select, and reading a result can acknowledge that slot's flag.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, `doneFlags`, `convCount`, `seqDone`, `irq`, `overrun`, `trigOverrun` and `convStart` are all zero.
- R2: A sequence holds `cfgLen` conversions for values 1 to 8. A `cfgLen` of 0, or any value above 8, gives 8 conversions.
- R3: With `cfgMulti` = 0, every conversion drives `convCh` with the start channel. With `cfgMulti` = 1, conversion i drives `(start + i) mod 8`, so the channel wraps from 7 to 0.
- R4: With `cfgScan` = 0, the block issues no further `convStart` after the last conversion of a sequence. With `cfgScan` = 1, the next sequence is issued right away, or is armed again when the trigger is enabled.
- R5: With `cfgFifo` = 0, conversion i of a sequence is written to slot i. With `cfgFifo` = 1, results go to consecutive slots, wrapping from 7 to 0, and the pointer carries across sequences. While a conversion is pending, `convCount` shows the slot that will receive it. `rdData` always shows the slot selected by `rdSel`.
- R6: Each accepted `convDone` sets exactly the flag bit of its destination slot. In fixed placement the flags fill from bit 0 upward.
- R7: `seqDone` goes high at the end of every sequence, including each repeat in continuous mode. It clears on `statusRd` or on a configuration write. `irq` equals `seqDone` while `cfgIrqEn` is 1.
- R8: With `cfgFastClr` = 1, a read (`rdEn` with `rdSel` = k) clears flag k. With `cfgFastClr` = 0, a read clears flag k only if a `statusRd` came after the flag was set. A read with no such `statusRd` leaves the flag set.
- R9: `overrun` goes high, and stays high, when a result is written to a slot whose flag is still set.
- R10: With `trigEn` = 1, nothing is issued until a trigger. In edge mode (`trigLevel` = 0), the trigger is a rising edge on `extTrig` (`trigPolHigh` = 1) or a falling edge (`trigPolHigh` = 0). In level mode, the trigger is `extTrig` being at the active level.
- R11: `trigOverrun` goes high when `extTrig` makes a transition into its active level while a conversion is being issued or is pending.
- R12: `cfgWr` aborts any sequence in progress and clears `doneFlags`, `convCount`, `seqDone`, `overrun` and `trigOverrun` in the following cycle. The new sequence then starts from position 0 and slot 0.
- R13: `convStart` is a single-cycle pulse, and only one conversion is pending at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWr | input | 1 | Configuration write strobe; aborts and restarts |
| cfgLen | input | 4 | Conversions per sequence (0 or >8 means 8) |
| cfgStartCh | input | 3 | First channel of the sequence |
| cfgMulti | input | 1 | 1: channel steps each conversion |
| cfgScan | input | 1 | 1: sequences repeat continuously |
| cfgFifo | input | 1 | 1: ring placement of results |
| cfgIrqEn | input | 1 | Enables irq from seqDone |
| cfgFastClr | input | 1 | 1: a result read clears its flag |
| trigEn | input | 1 | Waits for the external trigger |
| trigLevel | input | 1 | 1: level sensitive, 0: edge sensitive |
| trigPolHigh | input | 1 | 1: rising/high active, 0: falling/low |
| extTrig | input | 1 | External trigger input |
| convStart | output | 1 | Start pulse to the converter core |
| convCh | output | 3 | Channel for the issued conversion |
| convDone | input | 1 | Core done pulse |
| convData | input | 10 | Core result, valid with convDone |
| statusRd | input | 1 | Status read strobe |
| rdEn | input | 1 | Result read strobe |
| rdSel | input | 3 | Result slot select |
| rdData | output | 10 | Selected result slot |
| doneFlags | output | 8 | Per-slot complete flags |
| convCount | output | 3 | Slot receiving the current conversion |
| seqDone | output | 1 | Sequence-complete flag |
| irq | output | 1 | Sequence-complete interrupt pending |
| overrun | output | 1 | Result overwritten before read |
| trigOverrun | output | 1 | Trigger arrived while busy |

## Verification
The bench builds the block with its default eight slots and 10-bit results. With eight slots, a ring-placement run of three-conversion sequences reaches the 7-to-0 wrap and a deliberate overwrite in the third sequence. It also lets a multi-channel sequence starting at channel 6 cross the channel wrap. Random sample values across the full 10-bit range, a random core latency, and random length, start channel, mode and placement are mixed with directed runs. The directed runs cover both trigger modes and polarities, aborts in the middle of a sequence, and both flag-clearing disciplines.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  parameter int NUM_CH = 8;
  localparam int CH_W = $clog2(NUM_CH);
  localparam int LEN_W = CH_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_ISSUE, S_CONV} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic            clearAll;
    logic            wrRes;
    logic [CH_W-1:0] slot;
  } seqStrobe_t;
endpackage

// File: rtl/cseq_ctrl.sv
module cseq_ctrl
  import cseq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWr,
  input  logic [LEN_W-1:0] cfgLen,
  input  logic [CH_W-1:0]  cfgStartCh,
  input  logic             cfgMulti,
  input  logic             cfgScan,
  input  logic             cfgFifo,
  input  logic             trigEn,
  input  logic             trigLevel,
  input  logic             trigPolHigh,
  input  logic             extTrig,
  input  logic             statusRd,
  input  logic             convDone,
  output logic             convStart,
  output logic [CH_W-1:0]  convCh,
  output logic [CH_W-1:0]  convCount,
  output logic             seqDone,
  output logic             trigOverrun,
  output seqStrobe_t       strb
);
  seqState_t       st;
  logic [CH_W-1:0] pos, fifoPtr, lenM1, startCh;
  logic            multi, scan, fifo, tEn, tLvl, tPol;
  logic            extPrev, trigActive, trigRise, go, busy, lastConv;
  logic [CH_W-1:0] slot;

  assign trigActive = tPol ? extTrig : ~extTrig;
  assign trigRise   = tPol ? (extTrig & ~extPrev) : (~extTrig & extPrev);
  assign go         = tLvl ? trigActive : trigRise;
  assign busy       = (st == S_ISSUE) || (st == S_CONV);
  assign lastConv   = (pos == lenM1);
  assign slot       = fifo ? fifoPtr : pos;

  assign convStart = (st == S_ISSUE);
  assign convCh    = multi ? startCh + pos : startCh;
  assign convCount = slot;

  assign strb.clearAll = cfgWr;
  assign strb.wrRes    = (st == S_CONV) && convDone && !cfgWr;
  assign strb.slot     = slot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st          <= S_IDLE;
      pos         <= '0;
      fifoPtr     <= '0;
      lenM1       <= '0;
      startCh     <= '0;
      multi       <= 1'b0;
      scan        <= 1'b0;
      fifo        <= 1'b0;
      tEn         <= 1'b0;
      tLvl        <= 1'b0;
      tPol        <= 1'b0;
      extPrev     <= 1'b0;
      seqDone     <= 1'b0;
      trigOverrun <= 1'b0;
    end else begin
      extPrev <= extTrig;
      if (cfgWr) begin
        if (cfgLen == '0 || cfgLen > LEN_W'(NUM_CH)) lenM1 <= CH_W'(NUM_CH - 1);
        else                                         lenM1 <= CH_W'(cfgLen - 1'b1);
        startCh     <= cfgStartCh;
        multi       <= cfgMulti;
        scan        <= cfgScan;
        fifo        <= cfgFifo;
        tEn         <= trigEn;
        tLvl        <= trigLevel;
        tPol        <= trigPolHigh;
        pos         <= '0;
        fifoPtr     <= '0;
        seqDone     <= 1'b0;
        trigOverrun <= 1'b0;
        st          <= trigEn ? S_ARM : S_ISSUE;
      end else begin
        if (statusRd) seqDone <= 1'b0;
        if (tEn && trigRise && busy) trigOverrun <= 1'b1;
        case (st)
          S_ARM:   if (go) st <= S_ISSUE;
          S_ISSUE: st <= S_CONV;
          S_CONV: begin
            if (convDone) begin
              fifoPtr <= (fifoPtr == CH_W'(NUM_CH - 1)) ? '0 : fifoPtr + 1'b1;
              if (lastConv) begin
                pos     <= '0;
                seqDone <= 1'b1;
                if (scan) st <= tEn ? S_ARM : S_ISSUE;
                else      st <= S_IDLE;
              end else begin
                pos <= pos + 1'b1;
                st  <= S_ISSUE;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cseq_data.sv
module cseq_data
  import cseq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic [RES_W-1:0] wrData,
  input  logic             cfgFastClr,
  input  logic             statusRd,
  input  logic             rdEn,
  input  logic [CH_W-1:0]  rdSel,
  output logic [RES_W-1:0] rdData,
  output logic [NUM_CH-1:0] doneFlags,
  output logic             overrun
);
  logic [NUM_CH-1:0][RES_W-1:0] results;
  logic [NUM_CH-1:0] armed, rdHit, wrMask;

  always_comb begin
    for (int k = 0; k < NUM_CH; k++) begin
      rdHit[k] = rdEn && (rdSel == CH_W'(k)) && (cfgFastClr || armed[k]);
    end
    wrMask = strb.wrRes ? (NUM_CH'(1) << strb.slot) : '0;
  end

  assign rdData = results[rdSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      results   <= '0;
      doneFlags <= '0;
      armed     <= '0;
      overrun   <= 1'b0;
    end else if (strb.clearAll) begin
      doneFlags <= '0;
      armed     <= '0;
      overrun   <= 1'b0;
    end else begin
      doneFlags <= (doneFlags & ~rdHit) | wrMask;
      armed     <= (statusRd ? doneFlags : armed) & ~rdHit & ~wrMask;
      if (strb.wrRes) begin
        results[strb.slot] <= wrData;
        if (doneFlags[strb.slot] && !rdHit[strb.slot]) overrun <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import cseq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic [CH_W-1:0]   cfgStartCh,
  input  logic              cfgMulti,
  input  logic              cfgScan,
  input  logic              cfgFifo,
  input  logic              cfgIrqEn,
  input  logic              cfgFastClr,
  input  logic              trigEn,
  input  logic              trigLevel,
  input  logic              trigPolHigh,
  input  logic              extTrig,
  output logic              convStart,
  output logic [CH_W-1:0]   convCh,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convData,
  input  logic              statusRd,
  input  logic              rdEn,
  input  logic [CH_W-1:0]   rdSel,
  output logic [RES_W-1:0]  rdData,
  output logic [NUM_CH-1:0] doneFlags,
  output logic [CH_W-1:0]   convCount,
  output logic              seqDone,
  output logic              irq,
  output logic              overrun,
  output logic              trigOverrun
);
  seqStrobe_t strb;

  cseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgLen(cfgLen),
    .cfgStartCh(cfgStartCh), .cfgMulti(cfgMulti), .cfgScan(cfgScan),
    .cfgFifo(cfgFifo), .trigEn(trigEn), .trigLevel(trigLevel),
    .trigPolHigh(trigPolHigh), .extTrig(extTrig), .statusRd(statusRd),
    .convDone(convDone), .convStart(convStart), .convCh(convCh),
    .convCount(convCount), .seqDone(seqDone), .trigOverrun(trigOverrun),
    .strb(strb)
  );

  cseq_data #(.RES_W(RES_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(convData),
    .cfgFastClr(cfgFastClr), .statusRd(statusRd), .rdEn(rdEn),
    .rdSel(rdSel), .rdData(rdData), .doneFlags(doneFlags), .overrun(overrun)
  );

  assign irq = seqDone & cfgIrqEn;
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk
  import cseq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWr,
  input logic              convStart,
  input logic              convDone,
  input logic [NUM_CH-1:0] doneFlags,
  input logic [CH_W-1:0]   convCount,
  input logic              seqDone,
  input logic              overrun
);
  // R13
  single_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> !convStart);

  // R12
  cfg_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (doneFlags == '0 && convCount == '0 && !seqDone && !overrun));

  // R7
  seq_done_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqDone) |-> $past(convDone));

  // R9
  ovr_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(convDone));

  // R6
  flag_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(doneFlags & ~$past(doneFlags)));

  // R6
  flag_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((doneFlags & ~$past(doneFlags)) != '0) |-> $past(convDone));
endmodule

bind conv_sequencer conv_sequencer_chk u_chk (.*);

// File: tb/sim_conv_sequencer.sv
`timescale 1ns/1ps
module sim_conv_sequencer;
  logic clk = 0, rstN = 0;
  logic cfgWr = 0, cfgMulti = 0, cfgScan = 0, cfgFifo = 0, cfgIrqEn = 0, cfgFastClr = 0;
  logic [3:0] cfgLen = 0;
  logic [2:0] cfgStartCh = 0, rdSel = 0;
  logic trigEn = 0, trigLevel = 0, trigPolHigh = 0, extTrig = 0;
  logic convDone = 0, statusRd = 0, rdEn = 0;
  logic [9:0] convData = 0;
  logic convStart, seqDone, irq, overrun, trigOverrun;
  logic [2:0] convCh, convCount;
  logic [9:0] rdData;
  logic [7:0] doneFlags;

  int nTests = 0, nFail = 0;
  logic [9:0] mRes [8];
  logic [7:0] mFlags = 0;
  bit mOvr = 0;
  int mPtr = 0;
  int seedDummy;

  always #4 clk = ~clk;

  conv_sequencer u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int effLen(input int l);
    return (l == 0 || l > 8) ? 8 : l;
  endfunction

  function automatic int expCh(input int st, input int mul, input int i);
    return mul != 0 ? (st + i) % 8 : st;
  endfunction

  task automatic cfg(input int len, input int st, input int mul, input int scan,
                     input int fifo, input int tE, input int tL, input int tP);
    cfgLen = 4'(len); cfgStartCh = 3'(st); cfgMulti = mul[0]; cfgScan = scan[0];
    cfgFifo = fifo[0]; trigEn = tE[0]; trigLevel = tL[0]; trigPolHigh = tP[0];
    cfgWr = 1;
    @(negedge clk);
    cfgWr = 0;
    mFlags = 0; mOvr = 0; mPtr = 0;
  endtask

  task automatic serve(input int eCh, input int eSlot);
    int g = 0;
    int d;
    while (convStart !== 1'b1 && g < 200) begin @(negedge clk); g++; end
    if (g >= 200) begin chk(0, "R13 start missing", 0, 1); return; end
    chk(convCh == 3'(eCh), "R3 channel", convCh, eCh);
    chk(convCount == 3'(eSlot), "R5 counter", convCount, eSlot);
    @(negedge clk);
    chk(convStart == 0, "R13 pulse width", convStart, 0);
    repeat ($urandom_range(0, 2)) @(negedge clk);
    d = $urandom_range(0, 1023);
    convDone = 1; convData = 10'(d);
    @(negedge clk);
    convDone = 0;
    if (mFlags[eSlot]) mOvr = 1;
    mFlags[eSlot] = 1;
    mRes[eSlot] = 10'(d);
    chk(doneFlags == mFlags, "R6 flags", doneFlags, mFlags);
    chk(overrun == mOvr, "R9 overrun", overrun, mOvr);
  endtask

  task automatic runSeq(input int n, input int st, input int mul, input int fifo);
    for (int i = 0; i < n; i++) begin
      serve(expCh(st, mul, i), fifo != 0 ? mPtr : i);
      mPtr = (mPtr + 1) % 8;
    end
    chk(seqDone == 1, "R7 seqDone", seqDone, 1);
  endtask

  task automatic chkRes();
    for (int k = 0; k < 8; k++) begin
      if (mFlags[k]) begin
        rdSel = 3'(k);
        #1;
        chk(rdData == mRes[k], "R5 result", rdData, mRes[k]);
      end
    end
  endtask

  task automatic expectIdle(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (convStart) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic readSlot(input int k);
    rdSel = 3'(k); rdEn = 1;
    @(negedge clk);
    rdEn = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    seedDummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(doneFlags == 0 && convCount == 0, "R1 flags/count", doneFlags, 0);
    chk(!seqDone && !irq && !overrun && !trigOverrun && !convStart, "R1 status", seqDone, 0);
    rstN = 1;
    @(negedge clk);
    chk(convStart == 0, "R1 idle", convStart, 0);

    // R2 R3 R4 R7: single channel, one sequence, length 3
    cfgIrqEn = 1;
    cfg(3, 5, 0, 0, 0, 0, 0, 0);
    runSeq(3, 5, 0, 0);
    chk(irq == 1, "R7 irq", irq, 1);
    chkRes();
    @(negedge clk);
    expectIdle(8, "R4 single stops");

    // R8: read without status keeps flag
    cfgFastClr = 0;
    readSlot(1);
    chk(doneFlags[1] == 1, "R8 read alone", doneFlags[1], 1);
    statusRd = 1; @(negedge clk); statusRd = 0;
    chk(seqDone == 0 && irq == 0, "R7 status clears", seqDone, 0);
    readSlot(1);
    mFlags[1] = 0;
    chk(doneFlags == mFlags, "R8 status then read", doneFlags, mFlags);

    // R3 channel wrap, R8 fast clear, irq disabled
    cfgIrqEn = 0;
    cfg(4, 6, 1, 0, 0, 0, 0, 0);
    runSeq(4, 6, 1, 0);
    chk(irq == 0, "R7 irq disabled", irq, 0);
    chkRes();
    @(negedge clk);
    cfgFastClr = 1;
    readSlot(2);
    mFlags[2] = 0;
    chk(doneFlags == mFlags, "R8 fast clear", doneFlags, mFlags);
    cfgFastClr = 0;

    // R2 length 0 and 12 both mean 8
    cfg(0, 0, 1, 0, 0, 0, 0, 0);
    runSeq(8, 0, 1, 0);
    chkRes();
    expectIdle(5, "R2 len0 stops at 8");
    cfg(12, 3, 1, 0, 0, 0, 0, 0);
    runSeq(8, 3, 1, 0);
    expectIdle(5, "R2 len12 stops at 8");

    // R4 continuous, R9 overrun, R12 abort
    cfg(2, 3, 0, 1, 0, 0, 0, 0);
    runSeq(2, 3, 0, 0);
    runSeq(2, 3, 0, 0);
    chk(overrun == 1, "R9 overwrite", overrun, 1);
    chk(convStart == 1, "R4 continuous restart", convStart, 1);
    extTrig = 0;
    cfg(2, 1, 0, 0, 0, 1, 0, 1);
    chk(doneFlags == 0 && convCount == 0, "R12 abort clears", doneFlags, 0);
    chk(!overrun && !seqDone, "R12 sticky clear", overrun, 0);
    expectIdle(5, "R10 waits for trigger");

    // R5 FIFO placement across sequences with wrap
    cfg(3, 2, 1, 1, 1, 0, 0, 0);
    runSeq(3, 2, 1, 1);
    runSeq(3, 2, 1, 1);
    chk(overrun == 0, "R9 no overwrite yet", overrun, 0);
    runSeq(3, 2, 1, 1);
    chk(overrun == 1, "R9 fifo wrap overwrite", overrun, 1);
    chkRes();
    cfg(1, 0, 0, 0, 0, 1, 0, 1);
    chk(doneFlags == 0, "R12 fifo abort", doneFlags, 0);

    // R10 edge rising trigger, R11 trigger overrun
    cfg(2, 4, 1, 0, 0, 1, 0, 1);
    expectIdle(5, "R10 edge idle");
    extTrig = 1; @(negedge clk); extTrig = 0;
    serve(4, 0);
    chk(trigOverrun == 0, "R11 no overrun", trigOverrun, 0);
    extTrig = 1;
    serve(5, 1);
    extTrig = 0;
    chk(trigOverrun == 1, "R11 busy trigger", trigOverrun, 1);
    chk(seqDone == 1, "R7 triggered seq", seqDone, 1);
    expectIdle(5, "R4 triggered stop");

    // R10 level low
    extTrig = 1;
    cfg(1, 2, 0, 0, 0, 1, 1, 0);
    expectIdle(5, "R10 level inactive");
    extTrig = 0;
    serve(2, 0);
    extTrig = 1;
    chk(seqDone == 1, "R10 level sequence", seqDone, 1);
    expectIdle(4, "R10 level stop");

    // random single sequences (R2 R3 R5)
    for (int it = 0; it < 20; it++) begin
      int l, s, m, f;
      l = $urandom_range(0, 12); s = $urandom_range(0, 7);
      m = $urandom_range(0, 1);  f = $urandom_range(0, 1);
      cfg(l, s, m, 0, f, 0, 0, 0);
      runSeq(effLen(l), s, m, f);
      chkRes();
      expectIdle(3, "R4 random stop");
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule